// File: doc/BRIEF.md
# Reset Supervisor Sequencer

This block is the digital half of a reset generator. An external comparator reports whether the supply is above its threshold through `supply_ok`. The block runs from an always-present reference clock and drives the active-low system reset `rst_n_o`. Reset drops combinationally the moment `supply_ok` goes low, so it is asserted for as long as the supply is bad, however slowly or quickly the supply moves. Reset is released only through the reference clock, after a counted hold-off and after the monitored system clock `sys_clk` has shown that it toggles.

Low pulses on `supply_ok` pass through a two-flop synchronizer and a width filter. A pulse that is too short to count pulls reset low only while the pulse lasts and does not disturb the sequencing. A qualified dip sends the controller back to its supply-hold state and restarts the hold-off from zero. The sequence runs through four states: supply hold, hold-off count, clock check, and run. The clock monitor counts synchronized rising edges of `sys_clk` over a free-running window and also times the gap since the last edge. A clock that stops or slows while the system runs re-asserts reset. A two-bit code reports whether the most recent reset came from the supply or from the clock.

Top module: `rsup_top`

## Requirements
- R1: Whenever `supply_ok` is 0, `rst_n_o` is 0 in the same instant, with no dependence on the reference clock.
- R2: A `supply_ok` low pulse of GLITCH_CYC reference periods or longer forces the supply-hold state and restarts the hold-off from zero, even when the controller was part-way through the hold-off or was running.
- R3: While `supply_ok` stays low, for any duration, `rst_n_o` stays 0 and `cause_o` reads 2'b01.
- R4: After `supply_ok` rises and stays high, `rst_n_o` stays 0 for at least HOLD_CYC reference cycles. With the monitored clock running, it rises no later than HOLD_CYC + 2*WIN_CYC + 8 cycles after the rise.
- R5: A `supply_ok` low pulse of at most GLITCH_CYC-3 reference periods leaves the sequencing untouched: when the controller was running, `rst_n_o` is 1 again within 3 cycles of the pulse ending and stays 1.
- R6: Reset is not released until at least MIN_EDGES synchronized rising edges of `sys_clk` have been counted in one WIN_CYC-cycle window. A clock with fewer edges per window keeps reset asserted indefinitely.
- R7: When the monitored clock stops while reset is released, `rst_n_o` falls within TIMEOUT_CYC + 8 cycles. Once the clock runs again at a qualifying rate, reset is released within 2*WIN_CYC + 8 cycles, without a new hold-off.
- R8: `cause_o` holds the cause of the latest reset: 2'b01 for a qualified supply fault and 2'b10 for a clock fault. Each new reset overwrites it, and the value persists after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| supply_ok | input | 1 | Asynchronous supply-good from the comparator, 1 = above threshold |
| sys_clk | input | 1 | Monitored system clock, asynchronous to ref_clk |
| rst_n_o | output | 1 | Active-low system reset |
| cause_o | output | 2 | Cause of the latest reset: 01 supply, 10 clock |

## Verification
The assertions assume that `sys_clk` toggles at less than half the reference rate, with enough margin that each rising edge survives synchronization. They also assume that `supply_ok` changes no more often than the reference clock can see. The bench keeps within these limits. It drives `supply_ok` only at reference-clock falling edges, in whole-period pulses. It runs `sys_clk` with periods of five or nine reference cycles, or holds it still. Because `sys_clk` is unrelated to the reference clock, the bench checks release and fault latencies against windows derived from the parameters, not against single cycles.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_DELAY = 2'd1,
        ST_CHECK = 2'd2,
        ST_RUN   = 2'd3
    } sup_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_SUPPLY = 2'b01,
        CAUSE_CLOCK  = 2'b10
    } cause_e;

    typedef struct packed {
        logic alive;
        logic dead;
    } clk_stat_t;

    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic clr_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/rsup_glitch.sv
module rsup_glitch import rsup_pkg::*; #(
    parameter int unsigned GLITCH_CYC = 4
) (
    input  logic clk,
    input  logic ok_sync,
    output logic fault
);
    localparam int unsigned W = cnt_w(GLITCH_CYC);

    logic [W-1:0] low_cnt;

    // Self-initialising: saturates upward from any start value while low.
    always_ff @(posedge clk) begin
        if (ok_sync)                       low_cnt <= '0;
        else if (low_cnt < W'(GLITCH_CYC)) low_cnt <= low_cnt + 1'b1;
    end

    assign fault = (low_cnt >= W'(GLITCH_CYC));
endmodule

// File: rtl/rsup_clkmon.sv
module rsup_clkmon import rsup_pkg::*; #(
    parameter int unsigned WIN_CYC     = 64,
    parameter int unsigned MIN_EDGES   = 4,
    parameter int unsigned TIMEOUT_CYC = 128
) (
    input  logic      clk,
    input  logic      srst,
    input  logic      clk_sync,
    output clk_stat_t stat
);
    localparam int unsigned WW = cnt_w(WIN_CYC - 1);
    localparam int unsigned EW = cnt_w(MIN_EDGES);
    localparam int unsigned TW = cnt_w(TIMEOUT_CYC);

    logic          prev;
    logic          rise;
    logic          win_end;
    logic          dead;
    logic          alive_q;
    logic [WW-1:0] win_cnt;
    logic [EW-1:0] edge_cnt;
    logic [TW-1:0] idle_cnt;

    assign rise    = clk_sync & ~prev;
    assign win_end = (win_cnt == WW'(WIN_CYC - 1));
    assign dead    = (idle_cnt >= TW'(TIMEOUT_CYC));

    always_ff @(posedge clk) begin
        prev <= clk_sync;
        if (srst) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
            idle_cnt <= '0;
            alive_q  <= 1'b0;
        end else begin
            win_cnt <= win_end ? '0 : win_cnt + 1'b1;

            if (win_end)                                edge_cnt <= '0;
            else if (rise && edge_cnt < EW'(MIN_EDGES)) edge_cnt <= edge_cnt + 1'b1;

            if (rise)      idle_cnt <= '0;
            else if (!dead) idle_cnt <= idle_cnt + 1'b1;

            if (dead)         alive_q <= 1'b0;
            else if (win_end) alive_q <= (edge_cnt >= EW'(MIN_EDGES));
        end
    end

    assign stat.alive = alive_q;
    assign stat.dead  = dead;
endmodule

// File: rtl/rsup_ctrl.sv
module rsup_ctrl import rsup_pkg::*; #(
    parameter int unsigned HOLD_CYC = 3277
) (
    input  logic       clk,
    input  logic       srst,
    input  logic       ok_sync,
    input  clk_stat_t  stat,
    output sup_state_e state,
    output cause_e     cause,
    output logic       released
);
    localparam int unsigned HW = cnt_w(HOLD_CYC);

    logic [HW-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (srst) begin
            state    <= ST_HOLD;
            hold_cnt <= '0;
            cause    <= CAUSE_SUPPLY;
        end else begin
            case (state)
                ST_HOLD: begin
                    hold_cnt <= '0;
                    if (ok_sync) state <= ST_DELAY;
                end
                ST_DELAY: begin
                    if (hold_cnt == HW'(HOLD_CYC - 1)) state <= ST_CHECK;
                    else hold_cnt <= hold_cnt + 1'b1;
                end
                ST_CHECK: begin
                    if (stat.alive && !stat.dead) state <= ST_RUN;
                end
                default: begin
                    if (!stat.alive || stat.dead) begin
                        state <= ST_CHECK;
                        cause <= CAUSE_CLOCK;
                    end
                end
            endcase
        end
    end

    assign released = (state == ST_RUN);
endmodule

// File: rtl/rsup_top.sv
module rsup_top import rsup_pkg::*; #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned GLITCH_CYC  = 4,
    parameter int unsigned HOLD_CYC    = 3277,
    parameter int unsigned WIN_CYC     = 64,
    parameter int unsigned MIN_EDGES   = 4,
    parameter int unsigned TIMEOUT_CYC = 128
) (
    input  logic       ref_clk,
    input  logic       supply_ok,
    input  logic       sys_clk,
    output logic       rst_n_o,
    output logic [1:0] cause_o
);
    logic       ok_sync;
    logic       sclk_sync;
    logic       fault;
    logic       released;
    clk_stat_t  mon_stat;
    sup_state_e state;
    cause_e     cause;

    // Supply path: the comparator output itself clears the synchronizer.
    rsup_sync #(.STAGES(SYNC_STAGES)) u_sync_ok (
        .clk(ref_clk), .clr_n(supply_ok), .d(1'b1), .q(ok_sync)
    );

    rsup_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(ref_clk), .clr_n(1'b1), .d(sys_clk), .q(sclk_sync)
    );

    rsup_glitch #(.GLITCH_CYC(GLITCH_CYC)) u_glitch (
        .clk(ref_clk), .ok_sync(ok_sync), .fault(fault)
    );

    rsup_clkmon #(
        .WIN_CYC(WIN_CYC), .MIN_EDGES(MIN_EDGES), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_mon (
        .clk(ref_clk), .srst(fault), .clk_sync(sclk_sync), .stat(mon_stat)
    );

    rsup_ctrl #(.HOLD_CYC(HOLD_CYC)) u_ctrl (
        .clk(ref_clk), .srst(fault), .ok_sync(ok_sync), .stat(mon_stat),
        .state(state), .cause(cause), .released(released)
    );

    assign rst_n_o = released & supply_ok;
    assign cause_o = cause;
endmodule

// File: rtl/rsup_chk.sv
module rsup_chk import rsup_pkg::*; #(
    parameter int unsigned HOLD_CYC   = 3277,
    parameter int unsigned GLITCH_CYC = 4
) (
    input logic       clk,
    input logic       supply_ok,
    input logic       rst_n_o,
    input logic       fault,
    input logic       ok_sync,
    input logic       alive,
    input sup_state_e state,
    input logic [1:0] cause
);
    logic        armed = 1'b0;
    int unsigned since_fault = 0;
    int unsigned low_seen = 0;

    always_ff @(posedge clk) begin
        if (fault) armed <= 1'b1;
        if (fault) since_fault <= 0;
        else if (since_fault < HOLD_CYC + 4) since_fault <= since_fault + 1;
        if (ok_sync) low_seen <= 0;
        else if (low_seen < GLITCH_CYC + 4) low_seen <= low_seen + 1;
    end

    AST_LOW_SUPPLY_RESET: assert property (@(posedge clk) disable iff (!armed)
        !supply_ok |-> !rst_n_o); // R1
    AST_FAULT_RESTARTS: assert property (@(posedge clk) disable iff (!armed)
        fault |=> (state == ST_HOLD) && !rst_n_o); // R2
    AST_BROWNOUT_CAUSE: assert property (@(posedge clk) disable iff (!armed)
        fault |=> (cause == 2'b01)); // R3
    AST_HOLDOFF_MIN: assert property (@(posedge clk) disable iff (!armed)
        $rose(state == ST_RUN) |-> (since_fault >= HOLD_CYC)); // R4
    AST_FILTER_WIDTH: assert property (@(posedge clk) disable iff (!armed)
        $rose(fault) |-> (low_seen >= GLITCH_CYC)); // R5
    AST_RUN_NEEDS_ALIVE: assert property (@(posedge clk) disable iff (!armed)
        $rose(state == ST_RUN) |-> $past(alive)); // R6
    AST_CLOCK_FAULT: assert property (@(posedge clk) disable iff (!armed)
        (state == ST_RUN && !alive && !fault) |=> (cause == 2'b10) && !rst_n_o); // R7
    AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (!armed)
        $countones(cause) == 1); // R8
endmodule

bind rsup_top rsup_chk #(.HOLD_CYC(HOLD_CYC), .GLITCH_CYC(GLITCH_CYC)) u_chk (
    .clk(ref_clk), .supply_ok(supply_ok), .rst_n_o(rst_n_o), .fault(fault),
    .ok_sync(ok_sync), .alive(mon_stat.alive), .state(state), .cause(cause_o)
);

// File: tb/sim_rsup_top.sv
`timescale 1ns/1ps
module sim_rsup_top;
    localparam int GLITCH = 6;
    localparam int HOLD   = 50;
    localparam int WIN    = 16;
    localparam int EDGES  = 3;
    localparam int TMO    = 24;

    logic       ref_clk = 1'b0;
    logic       supply_ok = 1'b0;
    logic       sys_clk = 1'b0;
    logic       rst_n_o;
    logic [1:0] cause_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    bit  sys_run = 1'b1;
    int  sys_half = 20;

    rsup_top #(
        .SYNC_STAGES(2), .GLITCH_CYC(GLITCH), .HOLD_CYC(HOLD),
        .WIN_CYC(WIN), .MIN_EDGES(EDGES), .TIMEOUT_CYC(TMO)
    ) u0 (
        .ref_clk(ref_clk), .supply_ok(supply_ok), .sys_clk(sys_clk),
        .rst_n_o(rst_n_o), .cause_o(cause_o)
    );

    always #4 ref_clk = ~ref_clk;

    initial begin
        forever begin
            #(sys_half);
            if (sys_run) sys_clk = ~sys_clk;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge ref_clk);
    endtask

    task automatic until_high(output int n, input int limit);
        n = 0;
        while (!rst_n_o && n < limit) begin
            @(negedge ref_clk);
            n++;
        end
    endtask

    task automatic until_low(output int n, input int limit);
        n = 0;
        while (rst_n_o && n < limit) begin
            @(negedge ref_clk);
            n++;
        end
    endtask

    task automatic dip(input int len, output bit always_low);
        always_low = 1'b1;
        supply_ok = 1'b0;
        for (int i = 0; i < len; i++) begin
            #1;
            if (rst_n_o) always_low = 1'b0;
            @(negedge ref_clk);
        end
        supply_ok = 1'b1;
    endtask

    initial begin
        int  n;
        bit  lo;
        bit  stayed;
        @(negedge ref_clk);
        cycles(20);
        // Reset state
        chk(rst_n_o == 1'b0, "R1 reset state", rst_n_o, 0);
        chk(cause_o == 2'b01, "R8 reset-state cause", cause_o, 1);

        // R3: long brownout
        stayed = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(negedge ref_clk);
            if (rst_n_o) stayed = 1'b0;
        end
        chk(stayed, "R3 brownout holds reset", stayed, 1);
        chk(cause_o == 2'b01, "R3 brownout cause", cause_o, 1);

        // R4: first release
        supply_ok = 1'b1;
        until_high(n, 400);
        chk_rng("R4 hold-off latency", n, HOLD + 1, HOLD + 2*WIN + 8);

        // R5 / R1: short pulses ignored
        for (int len = 1; len <= GLITCH - 3; len++) begin
            dip(len, lo);
            chk(lo, "R1 reset low during pulse", lo, 1);
            cycles(3);
            chk(rst_n_o == 1'b1, "R5 short pulse back high", rst_n_o, 1);
            stayed = 1'b1;
            for (int i = 0; i < 60; i++) begin
                @(negedge ref_clk);
                if (!rst_n_o) stayed = 1'b0;
            end
            chk(stayed, "R5 no hold-off restart", stayed, 1);
        end

        // R2: qualified dips restart the hold-off
        for (int len = GLITCH; len <= GLITCH + 4; len++) begin
            dip(len, lo);
            chk(lo, "R1 reset low during dip", lo, 1);
            until_high(n, 400);
            chk_rng("R2 restart after dip", n, HOLD + 1, HOLD + 2*WIN + 8);
            chk(cause_o == 2'b01, "R8 supply cause", cause_o, 1);
        end

        // R2: dip in the middle of the hold-off
        dip(GLITCH + 2, lo);
        cycles(30);
        chk(rst_n_o == 1'b0, "R2 still holding", rst_n_o, 0);
        dip(GLITCH + 2, lo);
        until_high(n, 400);
        chk_rng("R2 restart from zero", n, HOLD + 1, HOLD + 2*WIN + 8);

        // R7: clock stop and resume
        cycles(10);
        sys_run = 1'b0;
        until_low(n, 200);
        chk_rng("R7 clock stop latency", n, 1, TMO + 8);
        chk(cause_o == 2'b10, "R8 clock cause", cause_o, 2);
        cycles(50);
        chk(rst_n_o == 1'b0, "R7 held while stopped", rst_n_o, 0);
        sys_run = 1'b1;
        until_high(n, 400);
        chk_rng("R7 resume without hold-off", n, 1, 2*WIN + 8);
        chk(cause_o == 2'b10, "R8 cause persists", cause_o, 2);

        // R6: slow clock never qualifies
        sys_half = 36;
        until_low(n, 200);
        chk_rng("R6 slow clock drops reset", n, 1, 2*WIN + 8);
        dip(GLITCH + 2, lo);
        stayed = 1'b1;
        for (int i = 0; i < HOLD + 200; i++) begin
            @(negedge ref_clk);
            if (rst_n_o) stayed = 1'b0;
        end
        chk(stayed, "R6 slow clock holds reset", stayed, 1);
        chk(cause_o == 2'b01, "R8 supply overwrites clock", cause_o, 1);
        sys_half = 20;
        until_high(n, 400);
        chk_rng("R6 release after clock qualifies", n, 1, 2*WIN + 8);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule